// File: doc/BRIEF.md
# ARINC 429 Serial Word Receiver

This block takes the digital output of a three-level line front end and rebuilds 32-bit ARINC 429 words from it. The front end gives two indications, one for a positive differential level and one for a negative one. When neither is asserted the line is at NULL. Every bit cell starts with a driven half, which is ONE or ZERO, and ends with a NULL half. The block samples each cell shortly after its driven half begins. The sampling runs on an oversampling tick, which comes from the master clock through a divider selected by a control input.

Words that show an illegal line level are dropped. A word also drops when it fails an optional match on its two source/destination bits. A word that passes is held in a one-word buffer and presented as two 16-bit halves with a fixed bit arrangement, and a ready flag rises. The host reads the two halves with one strobe each. A self-test input replaces the line inputs with the local transmitter's two output levels, so the transmit path can be looped back.

Top module: `a429_rx`

## Requirements
- R1: Serial bits are collected in order of arrival, and the first bit received is ARINC bit 1.
- R2: One oversampling tick occurs every DIV_FAST master clocks when `rate_sel` is 0, and every DIV_SLOW master clocks when it is 1. A bit cell lasts OVS ticks, so a word sent at the other rate is not accepted.
- R3: When `self_test_n` is 0, the receiver reads `tx_one`/`tx_zero` and ignores the line inputs. When it is 1, it reads `line_one`/`line_zero` and ignores the transmitter levels.
- R4: If both level indications are asserted at once at any point in a word, the word is discarded. The same applies if a sampled bit shows NULL.
- R5: When `dec_en` is 1, a word is accepted only if ARINC bit 9 equals `dec_a` and ARINC bit 10 equals `dec_b`. When `dec_en` is 0, the match is skipped.
- R6: `out_first` holds ARINC bits 13,12,11,10,9 on bits 15..11, bits 31,30,32 on bits 10..8, and bits 1 through 8 on bits 7 down to 0.
- R7: `out_second` holds ARINC bits 29 down to 14 on bits 15 down to 0.
- R8: A word ends after 32 sampled bits. NULL lasting GAP_BITS bit times resets the bit count and discards any partial word, and the next word is then received correctly.
- R9: `data_ready` rises when an accepted word is stored. It falls only after both `rd_first` and `rd_second` have been pulsed, in either order.
- R10: Storing a word while `data_ready` is still high replaces the buffer and sets `overrun`. `overrun` clears when both halves of the buffer are read.
- R11: After a synchronous reset (`rst_n` low on a clock edge), `data_ready` and `overrun` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rate_sel | input | 1 | Tick divider select: 0 fast, 1 slow |
| self_test_n | input | 1 | 0 routes transmitter levels into the receiver |
| dec_en | input | 1 | Enables the bit 9/10 match |
| dec_a | input | 1 | Required value of ARINC bit 9 |
| dec_b | input | 1 | Required value of ARINC bit 10 |
| line_one | input | 1 | Front end reports positive level |
| line_zero | input | 1 | Front end reports negative level |
| tx_one | input | 1 | Local transmitter drives positive level |
| tx_zero | input | 1 | Local transmitter drives negative level |
| rd_first | input | 1 | Read strobe for the first half |
| rd_second | input | 1 | Read strobe for the second half |
| out_first | output | 16 | First half of the stored word |
| out_second | output | 16 | Second half of the stored word |
| data_ready | output | 1 | A stored word waits to be read |
| overrun | output | 1 | An unread word was replaced |

## Verification
The bench uses the default parameters: DIV_FAST=10, DIV_SLOW=80, OVS=10 and GAP_BITS=4. With these values a fast-rate word takes about 3,200 clocks and a slow-rate word about 25,600. A received word can therefore be checked at both divider settings, and a fast-timed word can be sent while the slow divider is selected. The 4-bit gap fits well inside the null lead-in the bench puts before each word, so partial-word recovery, illegal levels and overrun can all be reached in a short run.

// File: rtl/a429_rx_pkg.sv
// Shared types and the bus packing for the ARINC 429 receiver.
// Assumes a received word is stored with ARINC bit n at index n-1.
package a429_rx_pkg;

    localparam int WORD_BITS = 32;
    localparam int HALF_W    = 16;

    typedef logic [WORD_BITS-1:0] rx_word_t;
    typedef logic [HALF_W-1:0]    half_t;

    // First bus half: label bits reversed in the low byte, SDI and SSM/parity above.
    function automatic half_t pack_first(rx_word_t w);
        half_t h;
        h[15] = w[12];
        h[14] = w[11];
        h[13] = w[10];
        h[12] = w[9];
        h[11] = w[8];
        h[10] = w[30];
        h[9]  = w[29];
        h[8]  = w[31];
        for (int i = 0; i < 8; i++) begin
            h[7-i] = w[i];
        end
        return h;
    endfunction

    // Second bus half: ARINC bits 29..14 in place.
    function automatic half_t pack_second(rx_word_t w);
        return w[28:13];
    endfunction

    // Source/destination match on ARINC bits 9 and 10.
    function automatic logic sd_match(rx_word_t w, logic en, logic a, logic b);
        return !en || ((w[8] == a) && (w[9] == b));
    endfunction

endpackage

// File: rtl/a429_tick_gen.sv
// Oversampling tick generator.
// Emits a one-cycle tick every DIV_FAST or DIV_SLOW master clocks, chosen by
// rate_sel. Assumes both divisors are at least 2.
module a429_tick_gen #(
    parameter int DIV_FAST = 10,
    parameter int DIV_SLOW = 80
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rate_sel,
    output logic tick
);

    localparam int CW = $clog2(DIV_SLOW);

    logic [CW-1:0] cnt;
    logic [CW-1:0] limit;

    // Select the terminal count for the active rate.
    always_comb begin
        limit = rate_sel ? CW'(DIV_SLOW - 1) : CW'(DIV_FAST - 1);
    end

    // Count master clocks and pulse tick at the terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (cnt >= limit) begin
            cnt  <= '0;
            tick <= 1'b1;
        end else begin
            cnt  <= cnt + 1'b1;
            tick <= 1'b0;
        end
    end

    AST_TICK_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R2

endmodule

// File: rtl/a429_bit_slicer.sv
// Line sampler and word assembler.
// Picks line or transmitter levels, registers them, detects the start of each
// driven half on a tick, samples it SAMPLE_PH ticks later and shifts the bit in.
// After 32 bits it pulses word_done with word_good. A run of GAP_BITS*OVS null
// ticks restarts the bit count. Assumes OVS >= 4.
module a429_bit_slicer
    import a429_rx_pkg::*;
#(
    parameter int OVS      = 10,
    parameter int GAP_BITS = 4
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     tick,
    input  logic     self_test_n,
    input  logic     line_one,
    input  logic     line_zero,
    input  logic     tx_one,
    input  logic     tx_zero,
    output logic     word_done,
    output logic     word_good,
    output rx_word_t word_data
);

    localparam int GAP_TICKS = GAP_BITS * OVS;
    localparam int GW        = $clog2(GAP_TICKS + 1);
    localparam int PW        = $clog2(OVS + 1);
    localparam int SAMPLE_PH = (OVS / 4 < 2) ? 2 : OVS / 4;
    localparam int BW        = $clog2(WORD_BITS);

    logic          sel_one, sel_zero;
    logic          one_q, zero_q;
    logic          is_null, is_bad;
    logic          prev_null, active, err;
    logic [PW-1:0] phase;
    logic [GW-1:0] gap_cnt;
    logic [BW-1:0] bit_cnt;
    rx_word_t      shreg;
    rx_word_t      shifted;

    // Choose loopback or line as the level source.
    always_comb begin
        sel_one  = self_test_n ? line_one  : tx_one;
        sel_zero = self_test_n ? line_zero : tx_zero;
    end

    // Register the chosen levels once per master clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            one_q  <= 1'b0;
            zero_q <= 1'b0;
        end else begin
            one_q  <= sel_one;
            zero_q <= sel_zero;
        end
    end

    // Classify the registered level and form the next shift value.
    always_comb begin
        is_null = !one_q && !zero_q;
        is_bad  = one_q && zero_q;
        shifted = {one_q, shreg[WORD_BITS-1:1]};
    end

    // Track the gap, bit phase, bit count and per-word error on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_null <= 1'b0;
            active    <= 1'b0;
            err       <= 1'b0;
            phase     <= '0;
            gap_cnt   <= '0;
            bit_cnt   <= '0;
            shreg     <= '0;
            word_done <= 1'b0;
            word_good <= 1'b0;
            word_data <= '0;
        end else begin
            word_done <= 1'b0;
            if (tick) begin
                prev_null <= is_null;
                if (!is_null) begin
                    gap_cnt <= '0;
                end else if (gap_cnt != GW'(GAP_TICKS)) begin
                    gap_cnt <= gap_cnt + 1'b1;
                end
                if (is_null && gap_cnt == GW'(GAP_TICKS - 1)) begin
                    bit_cnt <= '0;
                    err     <= 1'b0;
                    active  <= 1'b0;
                end else if (active) begin
                    if (phase == PW'(SAMPLE_PH)) begin
                        active <= 1'b0;
                        shreg  <= shifted;
                        if (bit_cnt == BW'(WORD_BITS - 1)) begin
                            word_done <= 1'b1;
                            word_good <= !(err || is_null || is_bad);
                            word_data <= shifted;
                            bit_cnt   <= '0;
                            err       <= 1'b0;
                        end else begin
                            bit_cnt <= bit_cnt + 1'b1;
                            if (is_null || is_bad) begin
                                err <= 1'b1;
                            end
                        end
                    end else begin
                        phase <= phase + 1'b1;
                        if (is_bad) begin
                            err <= 1'b1;
                        end
                    end
                end else begin
                    if (is_bad) begin
                        err <= 1'b1;
                    end
                    if (prev_null && !is_null && !is_bad) begin
                        active <= 1'b1;
                        phase  <= PW'(1);
                    end
                end
            end
        end
    end

    AST_DONE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        word_done |-> $past(tick)); // R2
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        word_done |=> !word_done); // R8
    AST_BAD_NOT_GOOD: assert property (@(posedge clk) disable iff (!rst_n)
        (word_done && word_good) |-> !$past(is_bad)); // R4

endmodule

// File: rtl/a429_word_hold.sv
// One-word output buffer.
// Applies the bit 9/10 match and stores accepted words as two bus halves.
// Keeps the ready and overrun flags and tracks which halves have been read.
// Assumes word_done is a single-cycle pulse.
module a429_word_hold
    import a429_rx_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     word_done,
    input  logic     word_good,
    input  rx_word_t word_data,
    input  logic     dec_en,
    input  logic     dec_a,
    input  logic     dec_b,
    input  logic     rd_first,
    input  logic     rd_second,
    output half_t    out_first,
    output half_t    out_second,
    output logic     data_ready,
    output logic     overrun
);

    logic latch;
    logic got_first, got_second;
    logic seen_first, seen_second;

    // Decide whether the finished word is stored; merge this cycle's reads.
    always_comb begin
        latch       = word_done && word_good && sd_match(word_data, dec_en, dec_a, dec_b);
        seen_first  = got_first  || rd_first;
        seen_second = got_second || rd_second;
    end

    // Store accepted words and manage ready, overrun and read tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_first  <= '0;
            out_second <= '0;
            data_ready <= 1'b0;
            overrun    <= 1'b0;
            got_first  <= 1'b0;
            got_second <= 1'b0;
        end else if (latch) begin
            out_first  <= pack_first(word_data);
            out_second <= pack_second(word_data);
            overrun    <= overrun || data_ready;
            data_ready <= 1'b1;
            got_first  <= 1'b0;
            got_second <= 1'b0;
        end else if (data_ready) begin
            if (seen_first && seen_second) begin
                data_ready <= 1'b0;
                overrun    <= 1'b0;
                got_first  <= 1'b0;
                got_second <= 1'b0;
            end else begin
                got_first  <= seen_first;
                got_second <= seen_second;
            end
        end
    end

    AST_READY_AFTER_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        latch |=> data_ready); // R9
    AST_READY_FALL_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(data_ready) |-> $past(rd_first || rd_second)); // R9
    AST_OVERRUN_ON_UNREAD: assert property (@(posedge clk) disable iff (!rst_n)
        (latch && data_ready) |=> overrun); // R10
    AST_SD_BITS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (latch && dec_en) |=> (out_first[11] == $past(dec_a) && out_first[12] == $past(dec_b))); // R5

endmodule

// File: rtl/a429_rx.sv
// ARINC 429 serial word receiver, top level.
// Connects the tick generator, the bit slicer and the one-word output buffer.
// Assumes the line indications are glitch-free digital levels from a front end.
module a429_rx
    import a429_rx_pkg::*;
#(
    parameter int DIV_FAST = 10,
    parameter int DIV_SLOW = 80,
    parameter int OVS      = 10,
    parameter int GAP_BITS = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rate_sel,
    input  logic        self_test_n,
    input  logic        dec_en,
    input  logic        dec_a,
    input  logic        dec_b,
    input  logic        line_one,
    input  logic        line_zero,
    input  logic        tx_one,
    input  logic        tx_zero,
    input  logic        rd_first,
    input  logic        rd_second,
    output logic [15:0] out_first,
    output logic [15:0] out_second,
    output logic        data_ready,
    output logic        overrun
);

    logic     tick;
    logic     word_done;
    logic     word_good;
    rx_word_t word_data;

    a429_tick_gen #(
        .DIV_FAST (DIV_FAST),
        .DIV_SLOW (DIV_SLOW)
    ) tick_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .rate_sel (rate_sel),
        .tick     (tick)
    );

    a429_bit_slicer #(
        .OVS      (OVS),
        .GAP_BITS (GAP_BITS)
    ) slicer_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick),
        .self_test_n (self_test_n),
        .line_one    (line_one),
        .line_zero   (line_zero),
        .tx_one      (tx_one),
        .tx_zero     (tx_zero),
        .word_done   (word_done),
        .word_good   (word_good),
        .word_data   (word_data)
    );

    a429_word_hold hold_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .word_done  (word_done),
        .word_good  (word_good),
        .word_data  (word_data),
        .dec_en     (dec_en),
        .dec_a      (dec_a),
        .dec_b      (dec_b),
        .rd_first   (rd_first),
        .rd_second  (rd_second),
        .out_first  (out_first),
        .out_second (out_second),
        .data_ready (data_ready),
        .overrun    (overrun)
    );

endmodule

// File: tb/a429_rx_tb_top.sv
module a429_rx_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int DIVF       = 10;
    localparam int DIVS       = 80;
    localparam int OVS        = 10;
    localparam int LEAD_BITS  = 6;
    localparam int WATCHDOG   = 190000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rate_sel = 1'b0, self_test_n = 1'b1;
    logic        dec_en = 1'b0, dec_a = 1'b0, dec_b = 1'b0;
    logic        line_one = 1'b0, line_zero = 1'b0, tx_one = 1'b0, tx_zero = 1'b0;
    logic        rd_first = 1'b0, rd_second = 1'b0;
    logic [15:0] out_first, out_second;
    logic        data_ready, overrun;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    a429_rx #(.DIV_FAST(DIVF), .DIV_SLOW(DIVS), .OVS(OVS), .GAP_BITS(4)) dut_i (
        .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel), .self_test_n(self_test_n),
        .dec_en(dec_en), .dec_a(dec_a), .dec_b(dec_b),
        .line_one(line_one), .line_zero(line_zero), .tx_one(tx_one), .tx_zero(tx_zero),
        .rd_first(rd_first), .rd_second(rd_second),
        .out_first(out_first), .out_second(out_second),
        .data_ready(data_ready), .overrun(overrun));

    // Expected halves, written from the requirement text (ARINC bit n = w[n-1]).
    function automatic logic [15:0] exp_first(logic [31:0] w);
        return {w[12], w[11], w[10], w[9], w[8], w[30], w[29], w[31],
                w[0], w[1], w[2], w[3], w[4], w[5], w[6], w[7]};
    endfunction

    function automatic logic [15:0] exp_second(logic [31:0] w);
        return w[28:13];
    endfunction

    task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input logic one, input logic zero, input logic use_tx);
        if (use_tx) begin
            tx_one = one; tx_zero = zero;
        end else begin
            line_one = one; line_zero = zero;
        end
    endtask

    // Null lead-in, nbits cells (bit i from w[i]; bad_bit drives both levels), null trail.
    task automatic send_word(input logic [31:0] w, input int nbits, input int div,
                             input int bad_bit, input logic use_tx);
        int half = div * OVS / 2;
        @(negedge clk);
        drive(1'b0, 1'b0, use_tx);
        repeat (LEAD_BITS * div * OVS) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            if (i == bad_bit) drive(1'b1, 1'b1, use_tx);
            else              drive(w[i], !w[i], use_tx);
            repeat (half) @(negedge clk);
            drive(1'b0, 1'b0, use_tx);
            repeat (half) @(negedge clk);
        end
        repeat (LEAD_BITS * div * OVS) @(negedge clk);
    endtask

    task automatic read_both();
        @(negedge clk); rd_first = 1'b1;
        @(negedge clk); rd_first = 1'b0; rd_second = 1'b1;
        @(negedge clk); rd_second = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        check(data_ready == 1'b0, "R11 ready after reset", {31'd0, data_ready}, 32'd0);
        check(overrun == 1'b0, "R11 overrun after reset", {31'd0, overrun}, 32'd0);
    endtask

    task automatic t_basic();
        logic [31:0] w = 32'hA5C3_1E69;
        send_word(w, 32, DIVF, -1, 1'b0);
        check(data_ready == 1'b1, "R9 ready after word", {31'd0, data_ready}, 32'd1);
        check(out_first == exp_first(w), "R6 R1 first half", {16'd0, out_first}, {16'd0, exp_first(w)});
        check(out_second == exp_second(w), "R7 second half", {16'd0, out_second}, {16'd0, exp_second(w)});
    endtask

    task automatic t_read();
        @(negedge clk); rd_first = 1'b1;
        @(negedge clk); rd_first = 1'b0;
        @(negedge clk);
        check(data_ready == 1'b1, "R9 ready held after one read", {31'd0, data_ready}, 32'd1);
        rd_second = 1'b1;
        @(negedge clk); rd_second = 1'b0;
        @(negedge clk);
        check(data_ready == 1'b0, "R9 ready cleared after both reads", {31'd0, data_ready}, 32'd0);
    endtask

    task automatic t_slow();
        logic [31:0] w = 32'h3C96_0F5A;
        rate_sel = 1'b1;
        send_word(w, 32, DIVS, -1, 1'b0);
        check(data_ready == 1'b1, "R2 slow word ready", {31'd0, data_ready}, 32'd1);
        check(out_first == exp_first(w) && out_second == exp_second(w), "R2 slow word data",
              {out_first, out_second}, {exp_first(w), exp_second(w)});
        read_both();
        send_word(32'h1234_5678, 32, DIVF, -1, 1'b0);
        check(data_ready == 1'b0, "R2 fast-timed word at slow divider rejected", {31'd0, data_ready}, 32'd0);
        rate_sel = 1'b0;
    endtask

    task automatic t_decoder();
        logic [31:0] w = 32'h0000_0200 | 32'h8421_0081;
        dec_en = 1'b1; dec_a = w[8]; dec_b = w[9];
        send_word(w, 32, DIVF, -1, 1'b0);
        check(data_ready == 1'b1 && out_second == exp_second(w), "R5 matching word accepted",
              {15'd0, data_ready, out_second}, {16'd1, exp_second(w)});
        read_both();
        dec_a = !w[8];
        send_word(w, 32, DIVF, -1, 1'b0);
        check(data_ready == 1'b0, "R5 mismatching word rejected", {31'd0, data_ready}, 32'd0);
        dec_en = 1'b0;
    endtask

    task automatic t_bad();
        send_word(32'hDEAD_BEEF, 32, DIVF, 17, 1'b0);
        check(data_ready == 1'b0, "R4 word with both levels rejected", {31'd0, data_ready}, 32'd0);
    endtask

    task automatic t_partial();
        logic [31:0] w = 32'h5A5A_C3C3;
        send_word(32'hFFFF_FFFF, 20, DIVF, -1, 1'b0);
        check(data_ready == 1'b0, "R8 partial word not stored", {31'd0, data_ready}, 32'd0);
        send_word(w, 32, DIVF, -1, 1'b0);
        check(data_ready == 1'b1 && out_first == exp_first(w) && out_second == exp_second(w),
              "R8 word after gap aligned", {out_first, out_second}, {exp_first(w), exp_second(w)});
        read_both();
    endtask

    task automatic t_overrun();
        logic [31:0] w1 = 32'h1111_2222;
        logic [31:0] w2 = 32'hF0E1_D2C3;
        send_word(w1, 32, DIVF, -1, 1'b0);
        check(overrun == 1'b0, "R10 no overrun on first word", {31'd0, overrun}, 32'd0);
        send_word(w2, 32, DIVF, -1, 1'b0);
        check(overrun == 1'b1, "R10 overrun on unread word", {31'd0, overrun}, 32'd1);
        check(out_first == exp_first(w2) && out_second == exp_second(w2), "R10 newer word kept",
              {out_first, out_second}, {exp_first(w2), exp_second(w2)});
        read_both();
        check(overrun == 1'b0 && data_ready == 1'b0, "R10 flags cleared by full read",
              {30'd0, overrun, data_ready}, 32'd0);
    endtask

    task automatic t_selftest();
        logic [31:0] w = 32'h6B2D_9E47;
        self_test_n = 1'b0;
        line_one = 1'b1; line_zero = 1'b0;
        send_word(w, 32, DIVF, -1, 1'b1);
        check(data_ready == 1'b1 && out_first == exp_first(w), "R3 loopback word received",
              {15'd0, data_ready, out_first}, {16'd1, exp_first(w)});
        read_both();
        self_test_n = 1'b1;
        line_one = 1'b0;
        send_word(w, 32, DIVF, -1, 1'b1);
        check(data_ready == 1'b0, "R3 transmitter ignored without self-test", {31'd0, data_ready}, 32'd0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_read();
        t_slow();
        t_decoder();
        t_bad();
        t_partial();
        t_overrun();
        t_selftest();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule